// File: doc/BRIEF.md
# Two-Level Translation Lookaside Lookup Array

This block stores and searches a translation cache made of two parts. The first part is set-associative: 8 ways of 256 sets, and every entry in it uses one page size that applies to the whole part. The second part is a small fully associative group of 8 entries, and each of those entries carries its own page size. Every entry maps a pair of adjacent pages, one even and one odd. The compare therefore uses the virtual page number divided by two, and the page-select bit itself is ignored.

A lookup presents a virtual address, the current address-space identifier and the shared page size. The block answers in the same cycle with a hit flag, the index of the matching entry and a multi-hit flag. Entries are written one at a time through a synchronous write port, addressed by the same index space that the lookup reports. Indices 0 to 2047 select the set-associative part as way*256 + set. Indices 2048 to 2055 select the associative entries.

Top module: `tlb_lookup_array`

## Requirements
- R1: After reset, no entry is present, so every lookup reports hit=0, hit_idx=0 and multi_hit=0. A write presented while rst is high is ignored.
- R2: A set-associative entry hits when all three conditions hold: its present bit is set, its stored identifier equals lk_asid, and its stored page number matches. The stored page number is wr_vppn, which holds address bits 47:13. When it hits, hit_idx = way*256 + set.
- R3: For the set-associative part, the set is the low 8 bits of (lk_va >> (sa_page_shift+1)). Only the 8 entries of that set are compared with the address.
- R4: An entry written with wr_global=1 matches for any lk_asid. An entry with wr_global=0 misses when its identifier differs from lk_asid.
- R5: The two addresses that differ only in bit sa_page_shift hit the same entry.
- R6: The set-associative compare is (lk_va >> (sa_page_shift+1)) == (vppn >> (sa_page_shift+1-13)). Changing sa_page_shift changes which set is searched and how many address bits take part in the compare.
- R7: An associative entry k occupies index 2048+k and compares using its own stored page size wr_ps, whatever sa_page_shift is. An address outside its even/odd pair misses.
- R8: When two set-associative entries hit, hit_idx is the lower index and multi_hit=1.
- R9: When a set-associative entry and an associative entry both hit, hit_idx is the set-associative index and multi_hit=1.
- R10: When two associative entries hit, hit_idx is the lower index and multi_hit=1.
- R11: A write takes effect from the clock edge that accepts it. During the cycle in which the write is presented, the lookup still shows the old contents. Writing wr_exist=0 removes the entry from later lookups.
- R12: When nothing hits, hit_idx=0 and multi_hit=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all present bits |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space identifier |
| sa_page_shift | input | 6 | log2 page size shared by the set-associative part (12 or more) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 12 | Entry index to write |
| wr_exist | input | 1 | Present bit to store |
| wr_global | input | 1 | Global bit to store |
| wr_asid | input | 16 | Identifier to store |
| wr_vppn | input | 35 | Page-pair number to store, address bits 47:13 |
| wr_ps | input | 6 | Page size to store, used only by associative entries |
| hit | output | 1 | At least one entry matches |
| hit_idx | output | 12 | Index of the matching entry with the highest priority |
| multi_hit | output | 1 | More than one entry matches |

## Verification
A write and a lookup of the same entry can fall in the same cycle. The bench provokes this by presenting a write to a second way of the set that the current lookup address selects, while the lookup stays unchanged. Before the clock edge it expects the old single hit. After the edge it expects the lower new index together with multi_hit. Removing the duplicate with a present bit of zero is judged the same way, and so are the cross-part duplicates that follow.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 48;
    localparam int ASID_W   = 16;
    localparam int PS_W     = 6;
    localparam int VPPN_LSB = 13;
    localparam int VPPN_W   = VA_W - VPPN_LSB;

    typedef struct packed {
        logic              global_pg;
        logic [ASID_W-1:0] asid;
        logic [VPPN_W-1:0] vppn;
        logic [PS_W-1:0]   ps;
    } tlb_tag_t;

    // Compare one stored tag with a lookup using page size ps.
    function automatic logic tag_match(
        input tlb_tag_t          t,
        input logic [VA_W-1:0]   va,
        input logic [ASID_W-1:0] cur_asid,
        input logic [PS_W-1:0]   ps
    );
        logic [VA_W-1:0] va_pair;
        logic [VA_W-1:0] tag_pair;
        va_pair  = va >> (int'(ps) + 1);
        tag_pair = VA_W'(t.vppn) >> (int'(ps) + 1 - VPPN_LSB);
        return (t.global_pg || (t.asid == cur_asid)) && (va_pair == tag_pair);
    endfunction

endpackage

// File: rtl/tlb_sa_part.sv
module tlb_sa_part
    import tlb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_exist,
    input  tlb_tag_t          wr_tag,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic [PS_W-1:0]   page_shift,
    output logic [WAYS-1:0]   way_hit,
    output logic [SET_W-1:0]  set_sel
);

    logic [SETS-1:0] exist_q [WAYS];
    tlb_tag_t        tags_q  [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                exist_q[w] <= '0;
            end
        end else if (we) begin
            exist_q[wr_way][wr_set] <= wr_exist;
            tags_q[wr_way][wr_set]  <= wr_tag;
        end
    end

    always_comb begin
        set_sel = SET_W'(va >> (int'(page_shift) + 1));
        for (int w = 0; w < WAYS; w++) begin
            way_hit[w] = exist_q[w][set_sel] &&
                         tag_match(tags_q[w][set_sel], va, asid, page_shift);
        end
    end

endmodule

// File: rtl/tlb_fa_part.sv
module tlb_fa_part
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_exist,
    input  tlb_tag_t          wr_tag,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic [ENTRIES-1:0] slot_hit
);

    logic [ENTRIES-1:0] exist_q;
    tlb_tag_t           tags_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            exist_q <= '0;
        end else if (we) begin
            exist_q[wr_slot] <= wr_exist;
            tags_q[wr_slot]  <= wr_tag;
        end
    end

    // Each entry compares with its own stored page size.
    always_comb begin
        for (int f = 0; f < ENTRIES; f++) begin
            slot_hit[f] = exist_q[f] && tag_match(tags_q[f], va, asid, tags_q[f].ps);
        end
    end

endmodule

// File: rtl/tlb_hit_merge.sv
module tlb_hit_merge #(
    parameter int WAYS  = 8,
    parameter int SETS  = 256,
    parameter int FA_N  = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int SA_TOTAL = WAYS * SETS,
    localparam int IDX_W = $clog2(SA_TOTAL + FA_N)
) (
    input  logic [WAYS-1:0]  sa_hit,
    input  logic [SET_W-1:0] set_sel,
    input  logic [FA_N-1:0]  fa_hit,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             multi_hit
);

    int unsigned n_hits;

    // Scan from the highest priority index down so the lowest index wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        n_hits  = 0;
        for (int f = FA_N - 1; f >= 0; f--) begin
            if (fa_hit[f]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(SA_TOTAL + f);
                n_hits  = n_hits + 1;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (sa_hit[w]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(w * SETS) | IDX_W'(set_sel);
                n_hits  = n_hits + 1;
            end
        end
        multi_hit = (n_hits > 1);
    end

endmodule

// File: rtl/tlb_lookup_array.sv
module tlb_lookup_array
    import tlb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int FA_N = 8,
    localparam int WAY_W    = $clog2(WAYS),
    localparam int SET_W    = $clog2(SETS),
    localparam int SLOT_W   = $clog2(FA_N),
    localparam int SA_TOTAL = WAYS * SETS,
    localparam int TOTAL    = SA_TOTAL + FA_N,
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PS_W-1:0]   sa_page_shift,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_exist,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPPN_W-1:0] wr_vppn,
    input  logic [PS_W-1:0]   wr_ps,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              multi_hit
);

    tlb_tag_t          wr_tag;
    logic              sa_we;
    logic              fa_we;
    logic [WAY_W-1:0]  sa_way;
    logic [SET_W-1:0]  sa_set;
    logic [SLOT_W-1:0] fa_slot;
    logic [WAYS-1:0]   sa_hit;
    logic [SET_W-1:0]  set_sel;
    logic [FA_N-1:0]   fa_hit;

    // Index decode: low range is way*SETS+set, then the associative slots.
    always_comb begin
        wr_tag.global_pg = wr_global;
        wr_tag.asid      = wr_asid;
        wr_tag.vppn      = wr_vppn;
        wr_tag.ps        = wr_ps;
        sa_we   = wr_en && (wr_idx < IDX_W'(SA_TOTAL));
        fa_we   = wr_en && !sa_we && (wr_idx < IDX_W'(TOTAL));
        sa_way  = wr_idx[SET_W +: WAY_W];
        sa_set  = wr_idx[SET_W-1:0];
        fa_slot = SLOT_W'(wr_idx - IDX_W'(SA_TOTAL));
    end

    tlb_sa_part #(.WAYS(WAYS), .SETS(SETS)) u_sa (
        .clk        (clk),
        .rst        (rst),
        .we         (sa_we),
        .wr_way     (sa_way),
        .wr_set     (sa_set),
        .wr_exist   (wr_exist),
        .wr_tag     (wr_tag),
        .va         (lk_va),
        .asid       (lk_asid),
        .page_shift (sa_page_shift),
        .way_hit    (sa_hit),
        .set_sel    (set_sel)
    );

    tlb_fa_part #(.ENTRIES(FA_N)) u_fa (
        .clk      (clk),
        .rst      (rst),
        .we       (fa_we),
        .wr_slot  (fa_slot),
        .wr_exist (wr_exist),
        .wr_tag   (wr_tag),
        .va       (lk_va),
        .asid     (lk_asid),
        .slot_hit (fa_hit)
    );

    tlb_hit_merge #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_merge (
        .sa_hit    (sa_hit),
        .set_sel   (set_sel),
        .fa_hit    (fa_hit),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .multi_hit (multi_hit)
    );

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
    import tlb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int FA_N = 8,
    localparam int SET_W    = $clog2(SETS),
    localparam int SA_TOTAL = WAYS * SETS,
    localparam int TOTAL    = SA_TOTAL + FA_N,
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input logic              clk,
    input logic              rst,
    input logic [VA_W-1:0]   lk_va,
    input logic [PS_W-1:0]   sa_page_shift,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_exist,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_idx,
    input logic              multi_hit
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !hit);

    // R3
    set_of_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && (hit_idx < IDX_W'(SA_TOTAL))) |->
        (hit_idx[SET_W-1:0] == SET_W'(lk_va >> (int'(sa_page_shift) + 1))));

    // R7
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_idx < IDX_W'(TOTAL)));

    // R8
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit);

    // R11
    removed_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_exist) |=> !(hit && (hit_idx == $past(wr_idx))));

    // R12
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> ((hit_idx == '0) && !multi_hit));

endmodule

bind tlb_lookup_array tlb_lookup_chk #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_va         (lk_va),
    .sa_page_shift (sa_page_shift),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_exist      (wr_exist),
    .hit           (hit),
    .hit_idx       (hit_idx),
    .multi_hit     (multi_hit)
);

// File: tb/tlb_lookup_array_bench.sv
`timescale 1ns/1ps
module tlb_lookup_array_bench;
    import tlb_pkg::*;

    localparam int IDX_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [PS_W-1:0]   sa_page_shift = 6'd12;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic              wr_exist = 1'b0;
    logic              wr_global = 1'b0;
    logic [ASID_W-1:0] wr_asid = '0;
    logic [VPPN_W-1:0] wr_vppn = '0;
    logic [PS_W-1:0]   wr_ps = '0;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              multi_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_lookup_array u_tlb_lookup_array (
        .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid),
        .sa_page_shift(sa_page_shift), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_exist(wr_exist), .wr_global(wr_global), .wr_asid(wr_asid),
        .wr_vppn(wr_vppn), .wr_ps(wr_ps), .hit(hit), .hit_idx(hit_idx),
        .multi_hit(multi_hit)
    );

    typedef struct packed {
        logic [47:0] va;
        logic [15:0] asid;
        logic [5:0]  ps;
        logic        e_hit;
        logic [11:0] e_idx;
        logic        e_multi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{48'h2466A000, 16'h0042, 6'd12, 1'b1, 12'd565,  1'b0},
        '{48'h2466B000, 16'h0042, 6'd12, 1'b1, 12'd565,  1'b0},
        '{48'h2466A000, 16'h0043, 6'd12, 1'b0, 12'd0,    1'b0},
        '{48'hF5700000, 16'h1234, 6'd12, 1'b1, 12'd896,  1'b0},
        '{48'h2466C000, 16'h0042, 6'd12, 1'b0, 12'd0,    1'b0},
        '{48'h407FFFF0, 16'h0042, 6'd12, 1'b1, 12'd2051, 1'b0},
        '{48'h40800000, 16'h0042, 6'd12, 1'b0, 12'd0,    1'b0},
        '{48'h40400000, 16'h0007, 6'd12, 1'b0, 12'd0,    1'b0},
        '{48'h2466A000, 16'h0042, 6'd13, 1'b1, 12'd410,  1'b0},
        '{48'h24668000, 16'h0042, 6'd13, 1'b1, 12'd410,  1'b0},
        '{48'h24668000, 16'h0042, 6'd12, 1'b0, 12'd0,    1'b0},
        '{48'h40400000, 16'h0042, 6'd13, 1'b1, 12'd2051, 1'b0}
    };
    localparam string VREQ [NV] = '{
        "R2", "R5", "R4", "R4", "R3", "R7", "R7", "R4", "R6", "R6", "R6", "R7"
    };

    task automatic chk(input string req, input logic e_hit,
                       input logic [11:0] e_idx, input logic e_multi);
        checks++;
        if (hit !== e_hit || hit_idx !== e_idx || multi_hit !== e_multi) begin
            errors++;
            $display("FAIL %s hit=%0b idx=%0d multi=%0b expected hit=%0b idx=%0d multi=%0b",
                     req, hit, hit_idx, multi_hit, e_hit, e_idx, e_multi);
        end
    endtask

    task automatic put(input logic [11:0] idx, input logic e, input logic g,
                       input logic [15:0] a, input logic [34:0] v, input logic [5:0] ps);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_exist = e; wr_global = g;
        wr_asid = a; wr_vppn = v; wr_ps = ps;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [47:0] va, input logic [15:0] a, input logic [5:0] ps);
        lk_va = va; lk_asid = a; sa_page_shift = ps;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        look(48'h2466A000, 16'h0042, 6'd12);
        chk("R1", 1'b0, 12'd0, 1'b0);

        put(12'd565,  1'b1, 1'b0, 16'h0042, 35'h12335, 6'd12);
        put(12'd896,  1'b1, 1'b1, 16'h0009, 35'h7AB80, 6'd12);
        put(12'd2051, 1'b1, 1'b0, 16'h0042, 35'h20300, 6'd21);
        put(12'd410,  1'b1, 1'b0, 16'h0042, 35'h12334, 6'd12);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            look(VECS[i].va, VECS[i].asid, VECS[i].ps);
            chk(VREQ[i], VECS[i].e_hit, VECS[i].e_idx, VECS[i].e_multi);
        end

        // R11: write and lookup of the same set in one cycle
        @(negedge clk);
        look(48'h2466A000, 16'h0042, 6'd12);
        wr_en = 1'b1; wr_idx = 12'd53; wr_exist = 1'b1; wr_global = 1'b0;
        wr_asid = 16'h0042; wr_vppn = 35'h12335; wr_ps = 6'd12;
        #0.5;
        chk("R11", 1'b1, 12'd565, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        // R8: two ways hit, lower index reported
        chk("R8", 1'b1, 12'd53, 1'b1);

        // R11: removal by present bit zero
        put(12'd53, 1'b0, 1'b0, 16'h0042, 35'h12335, 6'd12);
        #1;
        chk("R11", 1'b1, 12'd565, 1'b0);

        // R9: duplicate in the associative part
        put(12'd2052, 1'b1, 1'b0, 16'h0042, 35'h12335, 6'd12);
        #1;
        chk("R9", 1'b1, 12'd565, 1'b1);

        // R10: two associative entries hit
        put(12'd2054, 1'b1, 1'b1, 16'h0000, 35'h20200, 6'd21);
        look(48'h40400000, 16'h0042, 6'd12);
        chk("R10", 1'b1, 12'd2051, 1'b1);

        // R12: miss output is quiet
        look(48'h80000000, 16'h0042, 6'd12);
        chk("R12", 1'b0, 12'd0, 1'b0);

        // R1: reset again clears everything, write during reset ignored
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b1; wr_idx = 12'd565; wr_exist = 1'b1; wr_global = 1'b1;
        wr_vppn = 35'h12335;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        look(48'h2466A000, 16'h0042, 6'd12);
        chk("R1", 1'b0, 12'd0, 1'b0);
        look(48'h40400000, 16'h0042, 6'd12);
        chk("R1", 1'b0, 12'd0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule